// File: doc/BRIEF.md
# Warp-Granular Request Injection Throttle

This block sits between a compute core and the on-chip network. Each cycle it may be offered one warp request group: up to `NUM_REQ` memory requests, each lane tagged with a controller index and a bank index. The group is admitted as a whole, or it is held back as a whole. Two kinds of state decide admission. The first is a reservation counter for every controller/bank pair. The second is a count of the core's outstanding requests, checked against a programmable limit.

Once a group is admitted, every lane reserves its pair and is counted as outstanding at once. The lanes are then sent to the network one per cycle over a valid/ready handshake. A completion return releases one reservation and one outstanding slot. A group that is held back stays on the input and is looked at again every cycle. Counters clamp at their limits instead of wrapping, and any clamp raises a sticky error flag.

Top module: `warp_inject_throttle`

## Requirements
- R1: A presented group is admitted only if every reservation counter targeted by a masked lane reads zero in that cycle. Otherwise `throttle_o` is high and `grp_accept_o` is low. A lane's pair is the concatenation {controller, bank}.
- R2: A presented group is admitted only if the outstanding count is strictly below `thresh_i`. A threshold of zero never admits.
- R3: At admission, each masked lane adds one to its pair counter, so two lanes on one pair add two. The outstanding count grows by the number of masked lanes. Zero-checks see the values from before the group.
- R4: A group that is held back issues no request. It is re-evaluated every cycle and is admitted, with `grp_accept_o` high, in the first cycle that R1 and R2 both hold. `grp_accept_o` and `throttle_o` are never high together.
- R5: The lanes of an admitted group are issued in ascending lane order, starting the cycle after admission, one per accepted handshake. While `req_ready_i` is low, `req_valid_o`, `req_ctrl_o` and `req_bank_o` hold steady.
- R6: While requests of a group are still pending, no group is admitted and `throttle_o` stays low.
- R7: A completion return decrements its pair counter and the outstanding count at the same clock edge. A group blocked only by that reservation is admitted in the next cycle.
- R8: A counter that would exceed its maximum holds the maximum, and a counter that would go below zero holds zero. Either event sets `err_o` from the next cycle on until reset.
- R9: After reset, all counters are zero, `req_valid_o` and `err_o` are low, and the first clean group offered is admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_i | input | OUT_W | Outstanding-request limit |
| grp_valid_i | input | 1 | A warp group is presented |
| grp_mask_i | input | NUM_REQ | Lanes that carry a request |
| grp_ctrl_i | input | NUM_REQ*CTRL_W | Controller index per lane |
| grp_bank_i | input | NUM_REQ*BANK_W | Bank index per lane |
| grp_accept_o | output | 1 | The group is admitted this cycle |
| throttle_o | output | 1 | The group is held back this cycle |
| req_valid_o | output | 1 | A request is offered to the network |
| req_ready_i | input | 1 | The network takes the offered request |
| req_ctrl_o | output | CTRL_W | Controller index of the offered request |
| req_bank_o | output | BANK_W | Bank index of the offered request |
| cpl_valid_i | input | 1 | A completion return arrives |
| cpl_ctrl_i | input | CTRL_W | Controller index of the completion |
| cpl_bank_i | input | BANK_W | Bank index of the completion |
| err_o | output | 1 | Sticky counter clamp error |

## Verification
A stale or wrong reservation counter shows up in the first cycle a group targets that pair, as a wrong admit or throttle decision. A wrong outstanding count shows up the same way once it crosses the threshold. Errors in the drain store show up as soon as the request is offered, as a wrong lane order or wrong indices. A missed clamp shows up one cycle later on `err_o`. The bench's reference model predicts the admit, throttle, request and error outputs every cycle, so a fault is seen within a cycle of reaching a port.

// File: rtl/wit_pkg.sv
package wit_pkg;
  function automatic int sat_max(input int w);
    return (1 << w) - 1;
  endfunction

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wit_sat_cnt.sv
module wit_sat_cnt #(
  parameter int W  = 2,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] inc_i,
  input  logic          dec_i,
  output logic [W-1:0]  cnt_o,
  output logic          ovf_o
);
  localparam int MAX = wit_pkg::sat_max(W);

  logic [W-1:0] cnt_q, cnt_d;
  int sum;

  always_comb begin
    sum   = int'(cnt_q) + int'(inc_i) - int'(dec_i);
    ovf_o = 1'b0;
    if (sum > MAX) begin
      cnt_d = W'(MAX);
      ovf_o = 1'b1;
    end else if (sum < 0) begin
      cnt_d = '0;
      ovf_o = 1'b1;
    end else begin
      cnt_d = W'(sum);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wit_admit.sv
module wit_admit #(
  parameter int NUM_REQ = 4,
  parameter int PAIR_W  = 3,
  parameter int CNT_W   = 2,
  parameter int OUT_W   = 4,
  parameter int IW      = 3
) (
  input  logic [NUM_REQ-1:0]           mask_i,
  input  logic [NUM_REQ*PAIR_W-1:0]    pair_i,
  input  logic [(1<<PAIR_W)*CNT_W-1:0] res_cnt_i,
  input  logic [OUT_W-1:0]             out_cnt_i,
  input  logic [OUT_W-1:0]             thresh_i,
  output logic                         clear_o,
  output logic                         room_o,
  output logic [(1<<PAIR_W)*IW-1:0]    inc_o
);
  localparam int NUM_PAIR = 1 << PAIR_W;

  logic [IW-1:0]     inc_a [NUM_PAIR];
  logic [PAIR_W-1:0] idx;

  always_comb begin
    clear_o = 1'b1;
    idx     = '0;
    for (int p = 0; p < NUM_PAIR; p++) inc_a[p] = '0;
    for (int l = 0; l < NUM_REQ; l++) begin
      if (mask_i[l]) begin
        idx        = pair_i[l*PAIR_W +: PAIR_W];
        inc_a[idx] = inc_a[idx] + 1'b1;
        if (res_cnt_i[int'(idx)*CNT_W +: CNT_W] != '0) clear_o = 1'b0;
      end
    end
    for (int p = 0; p < NUM_PAIR; p++) inc_o[p*IW +: IW] = inc_a[p];
  end

  assign room_o = (out_cnt_i < thresh_i);
endmodule

// File: rtl/wit_drain.sv
module wit_drain #(
  parameter int NUM_REQ = 4,
  parameter int PAIR_W  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [NUM_REQ-1:0]          mask_i,
  input  logic [NUM_REQ*PAIR_W-1:0]   pair_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic [PAIR_W-1:0]           pair_o
);
  localparam int LW = wit_pkg::idx_w(NUM_REQ);

  logic [NUM_REQ-1:0] pend_q;
  logic [PAIR_W-1:0]  pair_q [NUM_REQ];
  logic [LW-1:0]      sel;

  // lowest pending lane goes first
  always_comb begin
    sel = '0;
    for (int l = NUM_REQ - 1; l >= 0; l--) begin
      if (pend_q[l]) sel = LW'(l);
    end
  end

  assign valid_o = |pend_q;
  assign pair_o  = pair_q[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int l = 0; l < NUM_REQ; l++) pair_q[l] <= '0;
    end else if (load_i) begin
      pend_q <= mask_i;
      for (int l = 0; l < NUM_REQ; l++) pair_q[l] <= pair_i[l*PAIR_W +: PAIR_W];
    end else if (valid_o && ready_i) begin
      pend_q[sel] <= 1'b0;
    end
  end
endmodule

// File: rtl/warp_inject_throttle.sv
module warp_inject_throttle #(
  parameter int NUM_REQ = 4,
  parameter int CTRL_W  = 1,
  parameter int BANK_W  = 2,
  parameter int CNT_W   = 2,
  parameter int OUT_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [OUT_W-1:0]          thresh_i,
  input  logic                      grp_valid_i,
  input  logic [NUM_REQ-1:0]        grp_mask_i,
  input  logic [NUM_REQ*CTRL_W-1:0] grp_ctrl_i,
  input  logic [NUM_REQ*BANK_W-1:0] grp_bank_i,
  output logic                      grp_accept_o,
  output logic                      throttle_o,
  output logic                      req_valid_o,
  input  logic                      req_ready_i,
  output logic [CTRL_W-1:0]         req_ctrl_o,
  output logic [BANK_W-1:0]         req_bank_o,
  input  logic                      cpl_valid_i,
  input  logic [CTRL_W-1:0]         cpl_ctrl_i,
  input  logic [BANK_W-1:0]         cpl_bank_i,
  output logic                      err_o
);
  localparam int PAIR_W   = CTRL_W + BANK_W;
  localparam int NUM_PAIR = 1 << PAIR_W;
  localparam int IW       = $clog2(NUM_REQ + 1);

  logic [NUM_REQ*PAIR_W-1:0]  grp_pair;
  logic [NUM_PAIR*CNT_W-1:0]  res_cnt;
  logic [NUM_PAIR*IW-1:0]     res_inc;
  logic [NUM_PAIR-1:0]        res_ovf;
  logic [OUT_W-1:0]           out_cnt;
  logic [IW-1:0]              out_inc;
  logic                       out_ovf;
  logic                       clear, room, busy;
  logic [PAIR_W-1:0]          cpl_pair, req_pair;
  logic                       err_q;

  for (genvar l = 0; l < NUM_REQ; l++) begin : g_lane
    assign grp_pair[l*PAIR_W +: PAIR_W] = {grp_ctrl_i[l*CTRL_W +: CTRL_W],
                                           grp_bank_i[l*BANK_W +: BANK_W]};
  end

  assign cpl_pair = {cpl_ctrl_i, cpl_bank_i};

  wit_admit #(
    .NUM_REQ(NUM_REQ), .PAIR_W(PAIR_W), .CNT_W(CNT_W), .OUT_W(OUT_W), .IW(IW)
  ) u_admit (
    .mask_i    (grp_mask_i),
    .pair_i    (grp_pair),
    .res_cnt_i (res_cnt),
    .out_cnt_i (out_cnt),
    .thresh_i  (thresh_i),
    .clear_o   (clear),
    .room_o    (room),
    .inc_o     (res_inc)
  );

  assign grp_accept_o = grp_valid_i && !busy && clear && room;
  assign throttle_o   = grp_valid_i && !busy && !(clear && room);

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic [IW-1:0] inc_p;
    assign inc_p = grp_accept_o ? res_inc[p*IW +: IW] : '0;
    wit_sat_cnt #(.W(CNT_W), .IW(IW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc_p),
      .dec_i  (cpl_valid_i && (cpl_pair == PAIR_W'(p))),
      .cnt_o  (res_cnt[p*CNT_W +: CNT_W]),
      .ovf_o  (res_ovf[p])
    );
  end

  assign out_inc = grp_accept_o ? IW'($countones(grp_mask_i)) : '0;

  wit_sat_cnt #(.W(OUT_W), .IW(IW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (out_inc),
    .dec_i  (cpl_valid_i),
    .cnt_o  (out_cnt),
    .ovf_o  (out_ovf)
  );

  wit_drain #(.NUM_REQ(NUM_REQ), .PAIR_W(PAIR_W)) u_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (grp_accept_o),
    .mask_i  (grp_mask_i),
    .pair_i  (grp_pair),
    .ready_i (req_ready_i),
    .valid_o (busy),
    .pair_o  (req_pair)
  );

  assign req_valid_o = busy;
  assign req_ctrl_o  = req_pair[PAIR_W-1:BANK_W];
  assign req_bank_o  = req_pair[BANK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | out_ovf | (|res_ovf);
  end

  assign err_o = err_q;
endmodule

// File: rtl/wit_checker.sv
module wit_checker #(
  parameter int NUM_REQ = 4,
  parameter int CTRL_W  = 1,
  parameter int BANK_W  = 2,
  parameter int OUT_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OUT_W-1:0]   thresh_i,
  input logic [NUM_REQ-1:0] grp_mask_i,
  input logic               grp_accept_o,
  input logic               throttle_o,
  input logic               req_valid_o,
  input logic               req_ready_i,
  input logic [CTRL_W-1:0]  req_ctrl_o,
  input logic [BANK_W-1:0]  req_bank_o,
  input logic               err_o,
  input logic [OUT_W-1:0]   out_cnt_i
);
  AST_ROOM_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_accept_o |-> (out_cnt_i < thresh_i)); // R2

  AST_ACCEPT_THROTTLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_accept_o && throttle_o)); // R4

  AST_THROTTLE_NO_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_o |=> !req_valid_o); // R4

  AST_ACCEPT_STARTS_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_accept_o && (grp_mask_i != '0)) |=> req_valid_o); // R5

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_ctrl_o) && $stable(req_bank_o))); // R5

  AST_NO_ACCEPT_WHILE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (!grp_accept_o && !throttle_o)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
endmodule

bind warp_inject_throttle wit_checker #(
  .NUM_REQ(NUM_REQ), .CTRL_W(CTRL_W), .BANK_W(BANK_W), .OUT_W(OUT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .thresh_i     (thresh_i),
  .grp_mask_i   (grp_mask_i),
  .grp_accept_o (grp_accept_o),
  .throttle_o   (throttle_o),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_ctrl_o   (req_ctrl_o),
  .req_bank_o   (req_bank_o),
  .err_o        (err_o),
  .out_cnt_i    (out_cnt)
);

// File: tb/warp_inject_throttle_test.sv
module warp_inject_throttle_test;
  localparam int NR = 4, CW = 1, BW = 2, CNTW = 2, OW = 4;
  localparam int NP = 8, CMAX = 3, OMAX = 15;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [OW-1:0] thresh_i = '0;
  logic grp_valid_i = 1'b0;
  logic [NR-1:0] grp_mask_i = '0;
  logic [NR*CW-1:0] grp_ctrl_i = '0;
  logic [NR*BW-1:0] grp_bank_i = '0;
  logic req_ready_i = 1'b0, cpl_valid_i = 1'b0;
  logic [CW-1:0] cpl_ctrl_i = '0;
  logic [BW-1:0] cpl_bank_i = '0;
  logic grp_accept_o, throttle_o, req_valid_o, err_o;
  logic [CW-1:0] req_ctrl_o;
  logic [BW-1:0] req_bank_o;

  warp_inject_throttle #(.NUM_REQ(NR), .CTRL_W(CW), .BANK_W(BW), .CNT_W(CNTW), .OUT_W(OW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .thresh_i(thresh_i), .grp_valid_i(grp_valid_i),
    .grp_mask_i(grp_mask_i), .grp_ctrl_i(grp_ctrl_i), .grp_bank_i(grp_bank_i),
    .grp_accept_o(grp_accept_o), .throttle_o(throttle_o), .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i), .req_ctrl_o(req_ctrl_o), .req_bank_o(req_bank_o),
    .cpl_valid_i(cpl_valid_i), .cpl_ctrl_i(cpl_ctrl_i), .cpl_bank_i(cpl_bank_i),
    .err_o(err_o));

  always #10 clk = ~clk;

  int res[NP];
  int outc;
  int pq[$];
  bit err_m;
  bit last_acc;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lane_pair(input int l);
    return (int'(grp_ctrl_i[l*CW +: CW]) << BW) | int'(grp_bank_i[l*BW +: BW]);
  endfunction

  function automatic bit m_accept();
    bit ok = grp_valid_i && (pq.size() == 0) && (outc < int'(thresh_i));
    for (int l = 0; l < NR; l++)
      if (grp_mask_i[l] && res[lane_pair(l)] != 0) ok = 1'b0;
    return ok;
  endfunction

  task automatic m_clear();
    for (int p = 0; p < NP; p++) res[p] = 0;
    outc = 0; pq.delete(); err_m = 1'b0;
  endtask

  // starts at a falling edge with inputs driven; ends at the next falling edge
  task automatic tick();
    bit acc, thr;
    int inc[NP];
    int n, s, cp;
    #2;
    acc = m_accept();
    thr = grp_valid_i && (pq.size() == 0) && !acc;
    chk("R1/R2/R9 accept", int'(grp_accept_o), int'(acc));
    chk("R4/R6 throttle", int'(throttle_o), int'(thr));
    chk("R5/R6 req_valid", int'(req_valid_o), int'(pq.size() != 0));
    if (pq.size() != 0)
      chk("R5 req pair", (int'(req_ctrl_o) << BW) | int'(req_bank_o), pq[0]);
    chk("R8 err", int'(err_o), int'(err_m));
    last_acc = acc;
    @(posedge clk);
    for (int p = 0; p < NP; p++) inc[p] = 0;
    n = 0;
    if (pq.size() != 0 && req_ready_i) void'(pq.pop_front());
    if (acc)
      for (int l = 0; l < NR; l++)
        if (grp_mask_i[l]) begin
          inc[lane_pair(l)]++; n++; pq.push_back(lane_pair(l));
        end
    cp = (int'(cpl_ctrl_i) << BW) | int'(cpl_bank_i);
    for (int p = 0; p < NP; p++) begin
      s = res[p] + inc[p] - ((cpl_valid_i && cp == p) ? 1 : 0);
      if (s > CMAX) begin s = CMAX; err_m = 1'b1; end
      if (s < 0) begin s = 0; err_m = 1'b1; end
      res[p] = s;
    end
    s = outc + n - (cpl_valid_i ? 1 : 0);
    if (s > OMAX) begin s = OMAX; err_m = 1'b1; end
    if (s < 0) begin s = 0; err_m = 1'b1; end
    outc = s;
    @(negedge clk);
  endtask

  task automatic set_grp(input bit v, input logic [NR-1:0] m,
                         input int p0, input int p1, input int p2, input int p3);
    int ps[NR];
    ps = '{p0, p1, p2, p3};
    grp_valid_i = v;
    grp_mask_i  = m;
    for (int l = 0; l < NR; l++) begin
      grp_ctrl_i[l*CW +: CW] = CW'(ps[l] >> BW);
      grp_bank_i[l*BW +: BW] = BW'(ps[l]);
    end
  endtask

  task automatic set_cpl(input bit v, input int p);
    cpl_valid_i = v;
    cpl_ctrl_i  = CW'(p >> BW);
    cpl_bank_i  = BW'(p);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_clear();
    #2;
    chk("R9 reset req_valid", int'(req_valid_o), 0);
    chk("R9 reset err", int'(err_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic peek(input string tag, input bit acc_exp, input bit thr_exp);
    #1;
    chk({tag, " accept"}, int'(grp_accept_o), int'(acc_exp));
    chk({tag, " throttle"}, int'(throttle_o), int'(thr_exp));
  endtask

  initial begin
    thresh_i = 4'd8;
    @(negedge clk);
    do_reset();

    // R9: first clean group admitted; R3/R5: four lanes drained in lane order
    set_grp(1, 4'b1111, 0, 1, 6, 7);
    peek("R9 first group", 1, 0);
    tick();
    set_grp(0, '0, 0, 0, 0, 0);
    req_ready_i = 1'b0;
    tick(); tick();            // R5 hold while not ready
    req_ready_i = 1'b1;
    repeat (4) tick();
    chk("R5 drained", int'(req_valid_o), 0);

    // R1/R4/R7: pair 1 reserved, throttled until its completion
    set_grp(1, 4'b0001, 1, 0, 0, 0);
    peek("R1 reserved pair", 0, 1);
    repeat (3) tick();
    set_cpl(1, 1);
    peek("R4 still held", 0, 1);
    tick();
    set_cpl(0, 0);
    peek("R7 after completion", 1, 0);
    tick();
    set_grp(0, '0, 0, 0, 0, 0);
    tick();
    foreach (res[p]) ;
    set_cpl(1, 0); tick(); set_cpl(1, 6); tick();
    set_cpl(1, 7); tick(); set_cpl(1, 1); tick();
    set_cpl(0, 0);

    // R3: duplicate lanes reserve pair 5 twice
    set_grp(1, 4'b0011, 5, 5, 0, 0);
    peek("R3 dup admit", 1, 0);
    tick();
    set_grp(0, '0, 0, 0, 0, 0);
    tick(); tick();
    set_grp(1, 4'b0001, 5, 0, 0, 0);
    set_cpl(1, 5);
    peek("R3 dup held", 0, 1);
    tick();
    set_cpl(1, 5);
    peek("R3 one release not enough", 0, 1);
    tick();
    set_cpl(0, 0);
    peek("R3 two releases", 1, 0);
    tick();
    set_grp(0, '0, 0, 0, 0, 0);
    tick();

    // R2: outstanding limit
    thresh_i = OW'(outc);
    set_grp(1, 4'b0001, 3, 0, 0, 0);
    peek("R2 at limit", 0, 1);
    tick();
    thresh_i = '0;
    peek("R2 zero limit", 0, 1);
    tick();
    thresh_i = OW'(outc + 1);
    peek("R2 below limit", 1, 0);
    tick();
    thresh_i = 4'd15;

    // R6: no admission while a group drains
    req_ready_i = 1'b0;
    set_grp(1, 4'b0001, 4, 0, 0, 0);
    peek("R6 during drain", 0, 0);
    tick(); tick();
    req_ready_i = 1'b1;
    tick();
    peek("R6 after drain", 1, 0);
    tick();
    set_grp(0, '0, 0, 0, 0, 0);
    tick();

    // R8: overflow clamp on a pair
    do_reset();
    set_grp(1, 4'b1111, 2, 2, 2, 2);
    tick();
    set_grp(0, '0, 0, 0, 0, 0);
    #1 chk("R8 overflow err", int'(err_o), 1);
    repeat (5) tick();
    chk("R8 err sticky", int'(err_o), 1);
    do_reset();
    chk("R9 err cleared", int'(err_o), 0);
    // R8: underflow clamp
    set_cpl(1, 4);
    tick();
    set_cpl(0, 0);
    #1 chk("R8 underflow err", int'(err_o), 1);
    tick();

    // mixed traffic against the model
    do_reset();
    thresh_i = 4'd10;
    last_acc = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (c % 250 == 0) thresh_i = OW'($urandom_range(12, 1));
      if (!grp_valid_i || last_acc) begin
        if ($urandom_range(9, 0) < 6)
          set_grp(1, NR'($urandom_range(15, 1)), $urandom_range(7, 0), $urandom_range(7, 0),
                  $urandom_range(7, 0), $urandom_range(7, 0));
        else
          set_grp(0, '0, 0, 0, 0, 0);
      end
      begin
        int p = $urandom_range(7, 0);
        if (res[p] > 0 && outc > 0 && $urandom_range(9, 0) < 4) set_cpl(1, p);
        else set_cpl(0, 0);
      end
      req_ready_i = ($urandom_range(9, 0) < 7);
      tick();
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule